// File: doc/BRIEF.md
# E1 Receive Channel Timing Generator

This block produces the per-timeslot and per-frame timing strobes that go with a 2.048 Mbit/s E1 receive serial stream. An upstream framer supplies a one-cycle alignment pulse in the cycle in which the serial input carries the first bit of timeslot 0 of frame 0. From then on the block counts bit positions within the 256-bit frame and frames within a 16-frame multiframe. Every output is registered on the rising edge of the bit clock and is aligned with the re-timed data bit it describes.

Downstream logic uses the channel strobe to convert serial data to parallel, the per-timeslot block output to gate clocks for fractional or drop-and-insert services, the sync pulse to find frame or multiframe starts, and the link clock to pick out the spare (Sa) bits of timeslot 0 from the link data output. The block mask is held in a shadow register that is reloaded only when a frame starts, so a timeslot is never partly blocked.

Top module: `e1_rx_chan_timer`

## Requirements
- R1: While reset is asserted, and after reset until the first alignment pulse, chan_clk_o, chan_blk_o, sync_o and link_clk_o are all low.
- R2: A high align_i sampled at a clock edge sets the position to bit 0 of timeslot 0 of frame 0 at that edge, at any point in the frame. Counting restarts from there.
- R3: chan_clk_o is high for exactly one cycle per timeslot, in the cycle where ser_o carries the eighth (least significant) bit of the timeslot. That bit is position 7 when counting from 0 at the MSB.
- R4: chan_blk_o equals bit n of the active mask for all eight cycles of timeslot n. Bit 0 maps to timeslot 0 and bit 31 to timeslot 31.
- R5: The active mask is loaded from blk_mask_i only at the edge that starts a frame: the alignment edge, or the edge after bit 255. A change of blk_mask_i at any other time has no effect until the next frame.
- R6: With sync_mf_i = 0, sync_o pulses for one cycle at bit 0 of every frame. With sync_mf_i = 1, it pulses only at bit 0 of frame 0 of each multiframe.
- R7: Frames are counted 0 to 15 and wrap back to 0. The frame after an alignment is frame 0.
- R8: link_clk_o is high on frame positions 3 to 7 of odd-numbered frames when the matching sa_en_i bit is set. sa_en_i[0] selects position 3 (Sa4) and sa_en_i[4] selects position 7 (Sa8). Each enabled bit gives 8 pulses per multiframe, which is 4 kHz.
- R9: ser_o and link_dat_o both equal ser_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low reset |
| align_i | input | 1 | Marks bit 0 of timeslot 0, frame 0 on ser_i |
| ser_i | input | 1 | Received serial data |
| blk_mask_i | input | 32 | Per-timeslot block mask, bit n for timeslot n |
| sync_mf_i | input | 1 | 0: sync marks frames, 1: sync marks multiframes |
| sa_en_i | input | 5 | Sa4..Sa8 link clock enables, bit 0 for Sa4 |
| ser_o | output | 1 | Re-timed serial data |
| link_dat_o | output | 1 | Full re-timed stream for the data link |
| link_clk_o | output | 1 | Qualifies the enabled Sa bits on link_dat_o |
| chan_clk_o | output | 1 | Last-bit-of-timeslot strobe (256 kHz) |
| chan_blk_o | output | 1 | Per-timeslot block level from the active mask |
| sync_o | output | 1 | One-cycle frame or multiframe start pulse |

## Verification
Two functions can fall in the same cycle. The channel strobe marks the eighth bit of timeslot 0, and in an odd frame that same bit is Sa8, which the link clock marks when enabled. The bench enables only Sa8, counts to frame 1, position 7, and requires both chan_clk_o and link_clk_o to be high there. Separately, a mask change in mid-frame is made to meet the frame-start reload: the old level must hold for the rest of the frame and the new level must appear in the next frame.

// File: rtl/e1_rxt_pkg.sv
package e1_rxt_pkg;
    localparam int unsigned TS_NUM    = 32;
    localparam int unsigned TS_BITS   = 8;
    localparam int unsigned MF_FRAMES = 16;
    localparam int unsigned SA_NUM    = 5;
    localparam int unsigned SA_LO     = 3;

    localparam int unsigned FRM_BITS = TS_NUM * TS_BITS;
    localparam int unsigned POS_W    = $clog2(FRM_BITS);
    localparam int unsigned BIT_W    = $clog2(TS_BITS);
    localparam int unsigned TS_W     = $clog2(TS_NUM);
    localparam int unsigned FRM_W    = $clog2(MF_FRAMES);

    typedef struct packed {
        logic             run;
        logic [POS_W-1:0] pos;
        logic [FRM_W-1:0] frm;
        logic             load;
    } e1_pos_t;

    typedef struct packed {
        logic              chan_clk;
        logic              chan_blk;
        logic              sync;
        logic              link_clk;
        logic              ser;
        logic [TS_NUM-1:0] mask;
    } e1_out_t;
endpackage

// File: rtl/e1_rxt_count.sv
module e1_rxt_count
    import e1_rxt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    align_i,
    output e1_pos_t nxt_o
);
    e1_pos_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.load = 1'b0;
        if (align_i) begin
            cnt_d.run  = 1'b1;
            cnt_d.pos  = '0;
            cnt_d.frm  = '0;
            cnt_d.load = 1'b1;
        end else if (cnt_q.run) begin
            if (cnt_q.pos == POS_W'(FRM_BITS - 1)) begin
                cnt_d.pos  = '0;
                cnt_d.load = 1'b1;
                if (cnt_q.frm == FRM_W'(MF_FRAMES - 1))
                    cnt_d.frm = '0;
                else
                    cnt_d.frm = cnt_q.frm + 1'b1;
            end else begin
                cnt_d.pos = cnt_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nxt_o = cnt_d;
endmodule

// File: rtl/e1_rxt_strobe.sv
module e1_rxt_strobe
    import e1_rxt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  e1_pos_t           nxt_i,
    input  logic [TS_NUM-1:0] blk_mask_i,
    input  logic              sync_mf_i,
    input  logic [SA_NUM-1:0] sa_en_i,
    input  logic              ser_i,
    output logic              chan_clk_o,
    output logic              chan_blk_o,
    output logic              sync_o,
    output logic              link_clk_o,
    output logic              ser_o
);
    e1_out_t          out_d, out_q;
    logic [SA_NUM-1:0] sa_hit;
    logic [TS_W-1:0]   ts_idx;
    logic [BIT_W-1:0]  bit_idx;

    assign ts_idx  = nxt_i.pos[POS_W-1:BIT_W];
    assign bit_idx = nxt_i.pos[BIT_W-1:0];

    for (genvar g = 0; g < SA_NUM; g++) begin : g_sa
        assign sa_hit[g] = sa_en_i[g] && (nxt_i.pos == POS_W'(SA_LO + g));
    end

    always_comb begin
        out_d          = out_q;
        out_d.mask     = nxt_i.load ? blk_mask_i : out_q.mask;
        out_d.chan_clk = nxt_i.run && (bit_idx == BIT_W'(TS_BITS - 1));
        out_d.chan_blk = nxt_i.run && out_d.mask[ts_idx];
        out_d.sync     = nxt_i.run && (nxt_i.pos == '0)
                         && (!sync_mf_i || nxt_i.frm == '0);
        out_d.link_clk = nxt_i.run && nxt_i.frm[0] && (|sa_hit);
        out_d.ser      = ser_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign chan_clk_o = out_q.chan_clk;
    assign chan_blk_o = out_q.chan_blk;
    assign sync_o     = out_q.sync;
    assign link_clk_o = out_q.link_clk;
    assign ser_o      = out_q.ser;
endmodule

// File: rtl/e1_rx_chan_timer.sv
module e1_rx_chan_timer
    import e1_rxt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_i,
    input  logic              ser_i,
    input  logic [TS_NUM-1:0] blk_mask_i,
    input  logic              sync_mf_i,
    input  logic [SA_NUM-1:0] sa_en_i,
    output logic              ser_o,
    output logic              link_dat_o,
    output logic              link_clk_o,
    output logic              chan_clk_o,
    output logic              chan_blk_o,
    output logic              sync_o
);
    e1_pos_t nxt;
    logic    ser_rt;

    e1_rxt_count u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .align_i (align_i),
        .nxt_o   (nxt)
    );

    e1_rxt_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_i      (nxt),
        .blk_mask_i (blk_mask_i),
        .sync_mf_i  (sync_mf_i),
        .sa_en_i    (sa_en_i),
        .ser_i      (ser_i),
        .chan_clk_o (chan_clk_o),
        .chan_blk_o (chan_blk_o),
        .sync_o     (sync_o),
        .link_clk_o (link_clk_o),
        .ser_o      (ser_rt)
    );

    assign ser_o      = ser_rt;
    assign link_dat_o = ser_rt;
endmodule

// File: rtl/e1_rxt_chk.sv
module e1_rxt_chk (
    input logic clk,
    input logic rst_n,
    input logic align_i,
    input logic chan_clk_o,
    input logic chan_blk_o,
    input logic sync_o,
    input logic link_clk_o
);
    // R3
    chan_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk_o |=> !chan_clk_o);

    // R6
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !align_i) |=> !sync_o);

    // R4
    blk_hold_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_clk_o && !align_i) |=> $stable(chan_blk_o));

    // R8
    link_not_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_clk_o |-> !sync_o);

    // R3
    sync_not_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> !chan_clk_o);
endmodule

bind e1_rx_chan_timer e1_rxt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .align_i    (align_i),
    .chan_clk_o (chan_clk_o),
    .chan_blk_o (chan_blk_o),
    .sync_o     (sync_o),
    .link_clk_o (link_clk_o)
);

// File: tb/e1_rx_chan_timer_tb.sv
module e1_rx_chan_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCASE = 4;
    // {sync_mf, sa_en[4:0], mask[31:0]}
    localparam logic [37:0] CASES [NCASE] = '{
        {1'b0, 5'b00001, 32'h0000_0001},
        {1'b1, 5'b11111, 32'hFFFF_0000},
        {1'b1, 5'b10100, 32'h8000_0001},
        {1'b0, 5'b01010, 32'h5A5A_C3C3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_i = 1'b0;
    logic        ser_i = 1'b0;
    logic [31:0] blk_mask_i = '0;
    logic        sync_mf_i = 1'b0;
    logic [4:0]  sa_en_i = '0;
    logic ser_o, link_dat_o, link_clk_o, chan_clk_o, chan_blk_o, sync_o;

    int errors = 0;
    int checks = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic        m_run = 1'b0;
    logic [7:0]  m_pos = '0;
    logic [3:0]  m_frm = '0;
    logic [31:0] m_mask = '0;
    logic        m_ser = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_rx_chan_timer u_dut (
        .clk(clk), .rst_n(rst_n), .align_i(align_i), .ser_i(ser_i),
        .blk_mask_i(blk_mask_i), .sync_mf_i(sync_mf_i), .sa_en_i(sa_en_i),
        .ser_o(ser_o), .link_dat_o(link_dat_o), .link_clk_o(link_clk_o),
        .chan_clk_o(chan_clk_o), .chan_blk_o(chan_blk_o), .sync_o(sync_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic       n_run = m_run;
        logic [7:0] n_pos = m_pos;
        logic [3:0] n_frm = m_frm;
        logic [31:0] n_mask = m_mask;
        logic e_cc, e_blk, e_sync, e_lk;
        if (align_i) begin
            n_run = 1'b1; n_pos = '0; n_frm = '0; n_mask = blk_mask_i;
        end else if (m_run) begin
            if (m_pos == 8'd255) begin
                n_pos = '0; n_frm = m_frm + 4'd1; n_mask = blk_mask_i;
            end else begin
                n_pos = m_pos + 8'd1;
            end
        end
        @(posedge clk);
        m_run = n_run; m_pos = n_pos; m_frm = n_frm; m_mask = n_mask;
        m_ser = ser_i;
        #2;
        e_cc   = m_run && (m_pos[2:0] == 3'd7);
        e_blk  = m_run && m_mask[m_pos[7:3]];
        e_sync = m_run && (m_pos == 8'd0) && (!sync_mf_i || m_frm == 4'd0);
        e_lk   = m_run && m_frm[0] && (m_pos >= 8'd3) && (m_pos <= 8'd7)
                 && sa_en_i[m_pos - 8'd3];
        chk(chan_clk_o == e_cc,  "R3", "chan_clk_o", int'(chan_clk_o), int'(e_cc));
        chk(chan_blk_o == e_blk, "R4/R5", "chan_blk_o", int'(chan_blk_o), int'(e_blk));
        chk(sync_o == e_sync,    "R6/R7", "sync_o", int'(sync_o), int'(e_sync));
        chk(link_clk_o == e_lk,  "R8", "link_clk_o", int'(link_clk_o), int'(e_lk));
        chk(ser_o == m_ser,      "R9", "ser_o", int'(ser_o), int'(m_ser));
        chk(link_dat_o == m_ser, "R9", "link_dat_o", int'(link_dat_o), int'(m_ser));
        @(negedge clk);
        lfsr  = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        ser_i = lfsr[0];
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int strobes;
        int n_lk;
        int n_sync;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({chan_clk_o, chan_blk_o, sync_o, link_clk_o} == 4'b0, "R1",
            "outputs in reset", int'({chan_clk_o, chan_blk_o, sync_o, link_clk_o}), 0);
        blk_mask_i = '1; sa_en_i = '1;
        rst_n = 1'b1;
        strobes = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            strobes += int'(chan_clk_o) + int'(chan_blk_o) + int'(sync_o) + int'(link_clk_o);
        end
        chk(strobes == 0, "R1", "strobes before alignment", strobes, 0);

        // Vector table: one full multiframe per case (R2, R6, R7, R8)
        for (int c = 0; c < NCASE; c++) begin
            sync_mf_i  = CASES[c][37];
            sa_en_i    = CASES[c][36:32];
            blk_mask_i = CASES[c][31:0];
            align_i    = 1'b1;
            tick();
            align_i = 1'b0;
            chk(sync_o == 1'b1, "R2", "sync after align", int'(sync_o), 1);
            n_lk = int'(link_clk_o);
            n_sync = int'(sync_o);
            for (int i = 1; i < 4096; i++) begin
                tick();
                n_lk += int'(link_clk_o);
                n_sync += int'(sync_o);
            end
            chk(n_lk == 8 * $countones(sa_en_i), "R8", "link pulses per multiframe",
                n_lk, 8 * $countones(sa_en_i));
            chk(n_sync == (sync_mf_i ? 1 : 16), "R6", "sync pulses per multiframe",
                n_sync, sync_mf_i ? 1 : 16);
            tick();
            chk(sync_o == 1'b1, "R7", "frame counter wraps to 0", int'(sync_o), 1);
            for (int i = 0; i < 9; i++) tick();
        end

        // R5: mask change in mid-frame waits for next frame
        sync_mf_i = 1'b0; sa_en_i = '0; blk_mask_i = '0;
        align_i = 1'b1;
        tick();
        align_i = 1'b0;
        for (int i = 1; i <= 165; i++) begin
            tick();
            if (i == 100) blk_mask_i = '1;
        end
        chk(chan_blk_o == 1'b0, "R5", "old mask held in slot 20", int'(chan_blk_o), 0);
        for (int i = 0; i < 256; i++) tick();
        chk(chan_blk_o == 1'b1, "R5", "new mask next frame", int'(chan_blk_o), 1);

        // R2: realignment in mid-frame
        align_i = 1'b1;
        tick();
        align_i = 1'b0;
        chk(sync_o == 1'b1, "R2", "sync after mid-frame align", int'(sync_o), 1);
        chk(chan_clk_o == 1'b0, "R2", "bit 0 after align", int'(chan_clk_o), 0);

        // R3 + R8 coincidence: Sa8 in frame 1 is last bit of timeslot 0
        sa_en_i = 5'b10000;
        for (int i = 0; i < 263; i++) tick();
        chk(chan_clk_o == 1'b1, "R3", "chan_clk on Sa8", int'(chan_clk_o), 1);
        chk(link_clk_o == 1'b1, "R8", "link_clk on Sa8", int'(link_clk_o), 1);
        tick();
        chk(link_clk_o == 1'b0, "R8", "link_clk after Sa8", int'(link_clk_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule